// File: doc/BRIEF.md
# Hybrid OR/XOR Clause Local-Search Flip Engine

This block runs a greedy stochastic local search over a Boolean formula that mixes two clause kinds. In an OR clause at least one literal must be true. In an XOR clause an odd number of literals must be true. The formula arrives as two literal masks and a per-clause type bit, and all three are held steady for the whole run.

From the current assignment the engine:

- works out which clauses are violated;
- counts for every variable how many violated clauses it would repair (make) and how many satisfied clauses it would spoil (break);
- adds an external signed noise value to each variable;
- flips the single variable with the best score.

Every variable that sits in a violated clause is scored in parallel.

A run begins with a one-cycle `start` pulse, which loads an initial assignment and an iteration limit. Each iteration then takes three cycles: clause evaluation, then make/break summation, then selection and flip. The run ends when every clause holds or when the iteration count reaches the limit. Control and status are plain level and pulse pins; no streaming interface is involved.

Top module: `sls_flip_core`

## Requirements
- R1: After reset, `busy`, `done` and `solved` are 0 and `iter_count` is 0.
- R2: While idle, a `start` pulse loads `init_assign` into `cur_assign` and captures `iter_limit`. It clears `iter_count`, `done` and `solved` and raises `busy`. A `start` seen while busy has no effect on the run.
- R3: Literal masks use bit `c*NV+v`. A bit set in `lit_pos` places literal x_v in clause c, and a bit set in `lit_neg` places literal NOT x_v there. An OR clause (`clause_xor[c]`=0) holds when its true-literal count is at least 1. An XOR clause (`clause_xor[c]`=1) holds when that count is odd.
- R4: A variable's make count is the number of violated clauses that contain it in either polarity.
- R5: A satisfied OR clause adds to a variable's break count only when the clause has exactly one true literal and that literal belongs to the variable. A satisfied XOR clause adds to the break count of every variable it contains.
- R6: The gain is make + noise − break. The noise for variable v is the two's-complement field `noise[v*NW +: NW]`. Only variables with make > 0 compete. The highest gain wins, and ties go to the lowest index. Exactly one bit of the assignment is flipped per iteration.
- R7: When no variable has make > 0, the iteration flips nothing but is still counted.
- R8: One iteration takes three cycles. `done` rises 3*k+1 clock edges after the edge that samples `start`, where k is the final `iter_count`.
- R9: The run stops with `done`=1 and `solved`=1 when all clauses hold at evaluation. It stops with `done`=1 and `solved`=0 when clauses are still violated and `iter_count` equals the captured limit. `iter_count` never exceeds that limit.
- R10: Once idle, `cur_assign`, `done`, `solved` and `iter_count` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request pulse, accepted when idle |
| init_assign | input | NV | Initial variable assignment |
| iter_limit | input | IW | Maximum number of iterations |
| lit_pos | input | NC*NV | Positive-literal mask, bit c*NV+v |
| lit_neg | input | NC*NV | Negated-literal mask, bit c*NV+v |
| clause_xor | input | NC | Clause type: 1 = XOR, 0 = OR |
| noise | input | NV*NW | Signed noise per variable |
| cur_assign | output | NV | Current assignment |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held) |
| solved | output | 1 | Finished with all clauses satisfied |
| iter_count | output | IW | Iterations performed in this run |

## Verification
Most internal faults surface within one three-cycle iteration:

- A wrong clause flag, a wrong make or break count, or a wrong tie rule changes which bit is flipped. That shows at once as a different `cur_assign`, and usually also as a different stopping point and `iter_count`.
- A sequencing fault moves the cycle at which `done` rises away from 3*k+1.
- A limit or termination fault shows up as a mismatched `solved` flag or iteration count.

The bench sweeps every initial assignment of a small formula and many pseudo-random formulas and noise vectors. For each run it compares the final assignment, the flag, the count and the latency against a model built from the requirements.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_EVAL  = 2'd1,
    PH_SCORE = 2'd2,
    PH_PICK  = 2'd3
  } phase_t;
endpackage

// File: rtl/sls_clause_eval.sv
// Per-clause true-literal count and status flags (first stage of an iteration).
module sls_clause_eval #(
  parameter int NV = 8,
  parameter int NC = 8
) (
  input  logic [NV-1:0]    x,
  input  logic [NC*NV-1:0] pos,
  input  logic [NC*NV-1:0] neg,
  input  logic [NC-1:0]    xor_sel,
  output logic [NC-1:0]    viol,
  output logic [NC-1:0]    brk,
  output logic             all_sat
);
  localparam int LW = $clog2(2*NV+1);

  for (genvar c = 0; c < NC; c++) begin : g_cl
    logic [2*NV-1:0] hits;
    logic [LW-1:0]   cnt;
    assign hits = {pos[c*NV +: NV] & x, neg[c*NV +: NV] & ~x};
    always_comb begin
      cnt = '0;
      for (int i = 0; i < 2*NV; i++) cnt = cnt + LW'(hits[i]);
    end
    // XOR: parity decides; OR: zero means violated, one means breakable
    assign viol[c] = xor_sel[c] ? ~cnt[0] : (cnt == '0);
    assign brk[c]  = xor_sel[c] ?  cnt[0] : (cnt == LW'(1));
  end

  assign all_sat = ~|viol;
endmodule

// File: rtl/sls_tally.sv
// Transposed-matrix sums: make and break counts per variable (second stage).
module sls_tally #(
  parameter int NV = 8,
  parameter int NC = 8,
  parameter int CW = 4
) (
  input  logic [NV-1:0]    x,
  input  logic [NC*NV-1:0] pos,
  input  logic [NC*NV-1:0] neg,
  input  logic [NC-1:0]    xor_sel,
  input  logic [NC-1:0]    viol,
  input  logic [NC-1:0]    brk,
  output logic [NV*CW-1:0] make_cnt,
  output logic [NV*CW-1:0] brk_cnt
);
  for (genvar v = 0; v < NV; v++) begin : g_var
    logic [CW-1:0] mk, bk;
    always_comb begin
      mk = '0;
      bk = '0;
      for (int c = 0; c < NC; c++) begin
        logic member, lit_on;
        member = pos[c*NV+v] | neg[c*NV+v];
        lit_on = (pos[c*NV+v] & x[v]) | (neg[c*NV+v] & ~x[v]);
        mk = mk + CW'(viol[c] & member);
        // OR clause: only the sole true literal's owner; XOR: every member
        bk = bk + CW'(brk[c] & member & (xor_sel[c] | lit_on));
      end
    end
    assign make_cnt[v*CW +: CW] = mk;
    assign brk_cnt[v*CW +: CW]  = bk;
  end
endmodule

// File: rtl/sls_pick.sv
// Gain formation and one-hot winner selection (third stage).
module sls_pick #(
  parameter int NV = 8,
  parameter int CW = 4,
  parameter int NW = 4
) (
  input  logic [NV*CW-1:0] make_cnt,
  input  logic [NV*CW-1:0] brk_cnt,
  input  logic [NV*NW-1:0] noise,
  output logic [NV-1:0]    win,
  output logic             any
);
  localparam int GW = CW + NW + 2;
  localparam logic signed [GW-1:0] GMIN = {1'b1, {(GW-1){1'b0}}};

  logic signed [GW-1:0] gain [NV];
  logic [NV-1:0]        elig;

  for (genvar v = 0; v < NV; v++) begin : g_gain
    logic [CW-1:0]        mk, bk;
    logic [NW-1:0]        nz;
    logic signed [GW-1:0] mk_s, bk_s, nz_s;
    assign mk   = make_cnt[v*CW +: CW];
    assign bk   = brk_cnt[v*CW +: CW];
    assign nz   = noise[v*NW +: NW];
    assign mk_s = $signed({{(GW-CW){1'b0}}, mk});
    assign bk_s = $signed({{(GW-CW){1'b0}}, bk});
    assign nz_s = $signed({{(GW-NW){nz[NW-1]}}, nz});
    assign elig[v] = (mk != '0);
    assign gain[v] = elig[v] ? (mk_s + nz_s - bk_s) : GMIN;
  end

  // Ascending scan with strict compare: ties keep the lower index
  always_comb begin
    logic signed [GW-1:0] best;
    best = GMIN;
    win  = '0;
    any  = 1'b0;
    for (int v = 0; v < NV; v++) begin
      if (elig[v] && (!any || gain[v] > best)) begin
        best   = gain[v];
        win    = '0;
        win[v] = 1'b1;
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sls_flip_core.sv
module sls_flip_core #(
  parameter int NV = 8,
  parameter int NC = 8,
  parameter int NW = 4,
  parameter int IW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NV-1:0]    init_assign,
  input  logic [IW-1:0]    iter_limit,
  input  logic [NC*NV-1:0] lit_pos,
  input  logic [NC*NV-1:0] lit_neg,
  input  logic [NC-1:0]    clause_xor,
  input  logic [NV*NW-1:0] noise,
  output logic [NV-1:0]    cur_assign,
  output logic             busy,
  output logic             done,
  output logic             solved,
  output logic [IW-1:0]    iter_count
);
  import sls_pkg::*;
  localparam int CW = $clog2(NC+1);

  phase_t          phase;
  logic [NV-1:0]   x_q;
  logic [IW-1:0]   lim_q, it_q;
  logic            done_q, solved_q;
  logic [NC-1:0]   viol_c, brk_c, viol_q, brk_q;
  logic            all_sat;
  logic [NV*CW-1:0] mk_c, bk_c, mk_q, bk_q;
  logic [NV-1:0]   win;
  logic            win_any;

  sls_clause_eval #(.NV(NV), .NC(NC)) u_eval (
    .x(x_q), .pos(lit_pos), .neg(lit_neg), .xor_sel(clause_xor),
    .viol(viol_c), .brk(brk_c), .all_sat(all_sat)
  );

  sls_tally #(.NV(NV), .NC(NC), .CW(CW)) u_tally (
    .x(x_q), .pos(lit_pos), .neg(lit_neg), .xor_sel(clause_xor),
    .viol(viol_q), .brk(brk_q), .make_cnt(mk_c), .brk_cnt(bk_c)
  );

  sls_pick #(.NV(NV), .CW(CW), .NW(NW)) u_pick (
    .make_cnt(mk_q), .brk_cnt(bk_q), .noise(noise),
    .win(win), .any(win_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      x_q      <= '0;
      lim_q    <= '0;
      it_q     <= '0;
      done_q   <= 1'b0;
      solved_q <= 1'b0;
      viol_q   <= '0;
      brk_q    <= '0;
      mk_q     <= '0;
      bk_q     <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          x_q      <= init_assign;
          lim_q    <= iter_limit;
          it_q     <= '0;
          done_q   <= 1'b0;
          solved_q <= 1'b0;
          phase    <= PH_EVAL;
        end
        PH_EVAL: begin
          viol_q <= viol_c;
          brk_q  <= brk_c;
          if (all_sat) begin
            done_q   <= 1'b1;
            solved_q <= 1'b1;
            phase    <= PH_IDLE;
          end else if (it_q == lim_q) begin
            done_q <= 1'b1;
            phase  <= PH_IDLE;
          end else begin
            phase <= PH_SCORE;
          end
        end
        PH_SCORE: begin
          mk_q  <= mk_c;
          bk_q  <= bk_c;
          phase <= PH_PICK;
        end
        PH_PICK: begin
          if (win_any) x_q <= x_q ^ win;
          it_q  <= it_q + IW'(1);
          phase <= PH_EVAL;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cur_assign = x_q;
  assign busy       = (phase != PH_IDLE);
  assign done       = done_q;
  assign solved     = solved_q;
  assign iter_count = it_q;
endmodule

// File: rtl/sls_flip_core_chk.sv
module sls_flip_core_chk #(
  parameter int NV = 8,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [NV-1:0] cur_assign,
  input logic          busy,
  input logic          done,
  input logic          solved,
  input logic [IW-1:0] iter_count,
  input logic [IW-1:0] lim_q
);
  assert_one_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($countones(cur_assign ^ $past(cur_assign)) <= 1));

  assert_iter_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter_count <= lim_q));

  assert_solved_implies_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    solved |-> done);

  assert_busy_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_iter_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      ((iter_count == $past(iter_count)) || (iter_count == $past(iter_count) + IW'(1))));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cur_assign) && $stable(done) && $stable(solved)));
endmodule

bind sls_flip_core sls_flip_core_chk #(.NV(NV), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cur_assign(cur_assign),
  .busy(busy), .done(done), .solved(solved), .iter_count(iter_count),
  .lim_q(lim_q)
);

// File: tb/sls_flip_core_tb.sv
module sls_flip_core_tb;
  localparam int NV = 4;
  localparam int NC = 4;
  localparam int NW = 4;
  localparam int IW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NV-1:0]    init_v = '0;
  logic [IW-1:0]    limit_v = '0;
  logic [NC*NV-1:0] pos_m = '0, neg_m = '0;
  logic [NC-1:0]    xor_m = '0;
  logic [NV*NW-1:0] noise_v = '0;
  logic [NV-1:0]    cur_assign;
  logic             busy, done, solved;
  logic [IW-1:0]    iter_count;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #(CLK_PERIOD/2) clk = ~clk;

  sls_flip_core #(.NV(NV), .NC(NC), .NW(NW), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .init_assign(init_v),
    .iter_limit(limit_v), .lit_pos(pos_m), .lit_neg(neg_m),
    .clause_xor(xor_m), .noise(noise_v), .cur_assign(cur_assign),
    .busy(busy), .done(done), .solved(solved), .iter_count(iter_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Requirement model: clause rules R3, make R4, break R5, selection R6/R7, stop R9
  task automatic model(input logic [15:0] p, input logic [15:0] n, input logic [3:0] xm,
                       input logic [15:0] nz, input logic [3:0] init, input int lim,
                       output logic [3:0] fa, output bit fs, output int fit);
    logic [3:0] x;
    bit vio [4];
    bit bkf [4];
    x = init; fit = 0; fs = 0;
    while (1) begin
      bit allsat;
      bit any;
      int best, bi;
      allsat = 1;
      for (int c = 0; c < NC; c++) begin
        int cnt;
        cnt = 0;
        for (int v = 0; v < NV; v++) begin
          if (p[c*4+v] && x[v]) cnt++;
          if (n[c*4+v] && !x[v]) cnt++;
        end
        if (xm[c]) begin vio[c] = (cnt % 2 == 0); bkf[c] = (cnt % 2 == 1); end
        else       begin vio[c] = (cnt == 0);     bkf[c] = (cnt == 1);     end
        if (vio[c]) allsat = 0;
      end
      if (allsat) begin fs = 1; break; end
      if (fit == lim) break;
      any = 0; best = 0; bi = 0;
      for (int v = 0; v < NV; v++) begin
        int mk, bk, g;
        mk = 0; bk = 0;
        for (int c = 0; c < NC; c++) begin
          bit mem, lt;
          mem = p[c*4+v] || n[c*4+v];
          lt  = (p[c*4+v] && x[v]) || (n[c*4+v] && !x[v]);
          if (vio[c] && mem) mk++;
          if (bkf[c] && mem && (xm[c] || lt)) bk++;
        end
        g = mk + int'($signed(nz[v*4 +: 4])) - bk;
        if (mk > 0 && (!any || g > best)) begin any = 1; best = g; bi = v; end
      end
      if (any) x[bi] = ~x[bi];
      fit++;
    end
    fa = x;
  endtask

  task automatic run_case(input string req, input logic [15:0] p, input logic [15:0] n,
                          input logic [3:0] xm, input logic [15:0] nz,
                          input logic [3:0] init, input int lim);
    logic [3:0] ea; bit es; int eit; int cyc;
    model(p, n, xm, nz, init, lim, ea, es, eit);
    @(negedge clk);
    pos_m = p; neg_m = n; xor_m = xm; noise_v = nz;
    init_v = init; limit_v = IW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    chk({req, " assign R6"}, int'(cur_assign), int'(ea));
    chk({req, " solved R9"}, int'(solved), int'(es));
    chk({req, " iter R9"}, int'(iter_count), eit);
    chk({req, " latency R8"}, cyc, 3*eit + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog act=expired exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] pa, na;
    logic [3:0]  xa;
    pa = 16'hC817; na = 16'h0280; xa = 4'b1001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 solved", int'(solved), 0);
    chk("R1 iter", int'(iter_count), 0);

    // R2 load with zero limit on an unsatisfied start point
    run_case("R2 limit0", pa, na, xa, 16'h0, 4'b0000, 0);
    chk("R2 loaded assign", int'(cur_assign), 0);

    // R3 sweep of all initial assignments of a mixed formula
    for (int i = 0; i < 16; i++) run_case("R3 sweep", pa, na, xa, 16'h0, 4'(i), 20);

    // R4 make counts: x1 sits in two violated clauses
    run_case("R4 make", 16'h0603, 16'h0, 4'b0000, 16'h0, 4'b0000, 5);
    chk("R4 make winner", int'(cur_assign), 2);
    // R5 OR break: x0 is sole true literal of a satisfied OR clause
    run_case("R5 or break", 16'h0303, 16'h1010, 4'b0000, 16'h0, 4'b0000, 5);
    chk("R5 or break winner", int'(cur_assign), 2);
    // R5 XOR break: x1 belongs to a satisfied XOR clause
    run_case("R5 xor break", 16'hA3A3, 16'h0, 4'b1010, 16'h0, 4'b1000, 5);
    chk("R5 xor break winner", int'(cur_assign), 9);
    // R6 tie toward lowest index, then noise moves the winner
    run_case("R6 tie", 16'hFFFF, 16'h0, 4'b0000, 16'h0, 4'b0000, 5);
    chk("R6 tie winner", int'(cur_assign), 1);
    run_case("R6 noise", 16'hFFFF, 16'h0, 4'b0000, 16'h0100, 4'b0000, 5);
    chk("R6 noise winner", int'(cur_assign), 4);
    run_case("R6 neg noise", 16'hFFFF, 16'h0, 4'b0000, 16'h00FF, 4'b0000, 5);
    chk("R6 neg noise winner", int'(cur_assign), 4);

    // R7 no candidates: all clauses empty and violated
    run_case("R7 no flip", 16'h0, 16'h0, 4'b0000, 16'h0, 4'b0101, 4);
    chk("R7 assign kept", int'(cur_assign), 5);

    // R9 already solved at start
    run_case("R9 presolved", 16'hFFFF, 16'h0, 4'b0000, 16'h0, 4'b1111, 3);

    // R10 outputs hold while idle, even if init changes
    begin
      logic [3:0] a0; logic d0, s0; logic [IW-1:0] i0;
      a0 = cur_assign; d0 = done; s0 = solved; i0 = iter_count;
      init_v = 4'b0110;
      repeat (5) @(negedge clk);
      chk("R10 hold assign", int'(cur_assign), int'(a0));
      chk("R10 hold done", int'(done), int'(d0));
      chk("R10 hold solved", int'(solved), int'(s0));
      chk("R10 hold iter", int'(iter_count), int'(i0));
    end

    // R2 start while busy is ignored
    begin
      int cyc;
      @(negedge clk);
      pos_m = '0; neg_m = '0; xor_m = '0; noise_v = '0;
      init_v = 4'b0101; limit_v = IW'(5); start = 1'b1;
      @(negedge clk);
      start = 1'b0; cyc = 0;
      repeat (3) begin @(negedge clk); cyc++; end
      init_v = 4'b1010; start = 1'b1;
      @(negedge clk); cyc++;
      start = 1'b0;
      while (!done && cyc < 400) begin @(negedge clk); cyc++; end
      chk("R2 busy start assign", int'(cur_assign), 5);
      chk("R2 busy start iter", int'(iter_count), 5);
      chk("R2 busy start latency R8", cyc, 16);
    end

    // Pseudo-random formulas, noise, start points and limits
    for (int k = 0; k < 60; k++) begin
      logic [15:0] p, n, nz;
      logic [3:0] xm, in0;
      int lim;
      p   = 16'(rnd() & rnd());
      n   = 16'(rnd() & rnd());
      xm  = 4'(rnd());
      nz  = (k % 2 == 0) ? 16'h0 : 16'(rnd());
      in0 = 4'(rnd());
      lim = int'(rnd() % 13);
      run_case("R5 random", p, n, xm, nz, in0, lim);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule